// File: doc/BRIEF.md
# Indirect Multichip Register Access Slave

This block is the chip-side end of a management bus. It lets one external bus address reach up to thirty-two internal register sets. The serial framing is left out. The bus arrives as a simple request port, where each request carries a bus (PHY) address, a register offset, a write flag and write data. The block answers each request with an acknowledge, a claim flag and read data.

When the strapped chip address is non-zero, the block only responds to that bus address. It then exposes two registers:

- **Command word (offset 0):** the host writes a command naming an internal device, a register offset and an operation. The block performs the access on an internal request/acknowledge port and shows a busy flag until the access completes.
- **Data word (offset 1):** holds the value for writes and receives the result of reads.

When the strap is zero, every bus address is claimed. The bus address is used directly as the internal device address, and the command/data pair is bypassed.

Devices that have no register set behind them are described by a mask parameter. Accesses to them never reach the internal port. Reads of them return all ones.

Top module: `mgmt_indirect_slave`

## Requirements
- R1: After reset, busy is 0, the command word and the data word read back as 0x0000, and both busAck and intReq are low.
- R2: With a non-zero strap, a request whose bus address differs from the strap is acknowledged one cycle later with busClaim=0 and read data 0xFFFF. Such a request has no effect on any register. A request to the strap address is acknowledged one cycle later with busClaim=1.
- R3: The command word is at offset 0 and is laid out as follows: bit 15 busy, bit 12 short-frame format, bits 11:10 opcode, bits 9:5 device address, bits 4:0 register offset. A read of it returns the written bits 14:0, with bit 15 replaced by the live busy flag.
- R4: A command starts an access only if bits 15 and 12 are both set and the opcode is 01 (write) or 10 (read). Any other command is stored but starts nothing, and busy stays 0.
- R5: A valid write command performs an internal write of the data word to the named device and offset. Busy reads 1 from the cycle after the command write until the internal acknowledge is taken, and then reads 0.
- R6: A valid read command performs an internal read. The returned value is loaded into the data word on the same clock edge at which busy clears.
- R7: While busy is 1, writes to the command word and to the data word are ignored.
- R8: A command to a device whose bit in DEV_MASK is 0 issues no internal request. Busy clears one cycle later, and a read command loads 0xFFFF into the data word.
- R9: Once raised, intReq stays high with intWe, intDev, intReg and intWdata unchanged until the cycle in which intAck is sampled high.
- R10: With a strap of zero, every bus address is claimed. The request is carried out directly on the internal port, with the bus address as device and the bus offset as register. It is acknowledged in the cycle after intAck, carrying the read data. An unmapped device is acknowledged one cycle after the request, with 0xFFFF.
- R11: With a non-zero strap, offsets other than 0 and 1 at the strap address read 0xFFFF, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipAddr | input | 5 | Strapped chip address; zero selects direct mode |
| busReq | input | 1 | One-cycle bus request strobe |
| busWe | input | 1 | Request is a write |
| busPhy | input | 5 | Bus address of the request |
| busReg | input | 5 | Register offset of the request |
| busWdata | input | 16 | Write data of the request |
| busAck | output | 1 | One-cycle response strobe |
| busClaim | output | 1 | The block answered this address |
| busRdData | output | 16 | Read data, valid with busAck |
| intReq | output | 1 | Internal access request, held until acknowledged |
| intWe | output | 1 | Internal access is a write |
| intDev | output | 5 | Internal device address |
| intReg | output | 5 | Internal register offset |
| intWdata | output | 16 | Internal write data |
| intAck | input | 1 | Internal access done |
| intRdata | input | 16 | Internal read data, valid with intAck |

## Verification
The assertions rely on three properties of the inputs:

- intAck is only raised while intReq is high.
- The strap changes only while reset is held.
- busReq is a single-cycle pulse that is not repeated while a direct-mode access is outstanding.

The bench respects all three. It drives one request at a time and waits for its acknowledge before starting the next. Its responder model raises intAck only against a live request, after a programmable latency. The strap is changed only inside a reset pulse.

// File: rtl/mis_pkg.sv
package mis_pkg;

  typedef enum logic [1:0] {
    RD_ONES,
    RD_CMD,
    RD_DATA,
    RD_INT
  } rdSel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_IND,
    ST_DIR
  } state_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic   ldCmd;
    logic   ldData;
    logic   capInt;
    logic   capOnes;
    logic   launchInd;
    logic   launchDir;
    logic   dropReq;
    logic   ack;
    logic   claim;
    rdSel_e rdSel;
  } strobe_t;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam int unsigned OFF_CMD  = 0;
  localparam int unsigned OFF_DATA = 1;

endpackage

// File: rtl/mis_ctrl.sv
module mis_ctrl
  import mis_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [2**ADDR_W-1:0] DEV_MASK = 'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] chipAddr,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busPhy,
  input  logic [ADDR_W-1:0] busReg,
  input  logic              cmdBusyBit,
  input  logic              cmdShortBit,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdDev,
  input  logic              cmdIsRead,
  input  logic              intReq,
  input  logic              intAck,
  output logic              busy,
  output strobe_t           st
);

  state_e state, nxtState;

  logic directMode;
  logic addrHit;
  logic cmdValid;
  logic isCmdOff;
  logic isDataOff;

  assign directMode = (chipAddr == '0);
  assign addrHit    = directMode || (busPhy == chipAddr);
  assign cmdValid   = cmdBusyBit && cmdShortBit && ((cmdOp == OP_WR) || (cmdOp == OP_RD));
  assign isCmdOff   = (busReg == ADDR_W'(OFF_CMD));
  assign isDataOff  = (busReg == ADDR_W'(OFF_DATA));
  assign busy       = (state == ST_IND);

  always_comb begin
    st       = '0;
    st.rdSel = RD_ONES;
    nxtState = state;

    // completion of the outstanding internal access
    case (state)
      ST_DIR: begin
        if (intReq && intAck) begin
          st.ack     = 1'b1;
          st.claim   = 1'b1;
          st.rdSel   = RD_INT;
          st.dropReq = 1'b1;
          nxtState   = ST_IDLE;
        end
      end
      ST_IND: begin
        if (!intReq || intAck) begin
          st.dropReq = 1'b1;
          if (cmdIsRead) begin
            if (intReq) st.capInt  = 1'b1;
            else        st.capOnes = 1'b1;
          end
          nxtState = ST_IDLE;
        end
      end
      default: ;
    endcase

    // bus side decode
    if (busReq && (state != ST_DIR)) begin
      if (!addrHit) begin
        st.ack   = 1'b1;
        st.claim = 1'b0;
        st.rdSel = RD_ONES;
      end else if (directMode) begin
        if (DEV_MASK[busPhy]) begin
          st.launchDir = 1'b1;
          nxtState     = ST_DIR;
        end else begin
          st.ack   = 1'b1;
          st.claim = 1'b1;
          st.rdSel = RD_ONES;
        end
      end else begin
        st.ack   = 1'b1;
        st.claim = 1'b1;
        if (isCmdOff) begin
          st.rdSel = RD_CMD;
          if (busWe && (state == ST_IDLE)) begin
            st.ldCmd = 1'b1;
            if (cmdValid) begin
              nxtState     = ST_IND;
              st.launchInd = DEV_MASK[cmdDev];
            end
          end
        end else if (isDataOff) begin
          st.rdSel = RD_DATA;
          if (busWe && (state == ST_IDLE)) st.ldData = 1'b1;
        end else begin
          st.rdSel = RD_ONES;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  // R10: a pending direct access always has a live internal request
  a_r10_dir_pending : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIR) |-> intReq);

  // R5: an acknowledged indirect access drops busy on the next cycle
  a_r5_busy_drop : assert property (@(posedge clk) disable iff (!rstN)
    (busy && intReq && intAck) |=> !busy);

  // R8: an indirect access without a request finishes after one cycle
  a_r8_unmapped_done : assert property (@(posedge clk) disable iff (!rstN)
    (busy && !intReq) |=> !busy);

endmodule

// File: rtl/mis_datapath.sv
module mis_datapath
  import mis_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [2**ADDR_W-1:0] DEV_MASK = 'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              busy,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busPhy,
  input  logic [ADDR_W-1:0] busReg,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              intAck,
  input  logic [DATA_W-1:0] intRdata,
  output logic              busAck,
  output logic              busClaim,
  output logic [DATA_W-1:0] busRdData,
  output logic              intReq,
  output logic              intWe,
  output logic [ADDR_W-1:0] intDev,
  output logic [ADDR_W-1:0] intReg,
  output logic [DATA_W-1:0] intWdata,
  output logic              cmdIsRead
);

  localparam int OP_LO  = 2 * ADDR_W;
  localparam int DEV_LO = ADDR_W;

  logic [DATA_W-2:0] cmdQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdQ;
  logic              ackQ;
  logic              claimQ;

  assign cmdIsRead = (cmdQ[OP_LO+1:OP_LO] == OP_RD);
  assign busAck    = ackQ;
  assign busClaim  = claimQ;
  assign busRdData = rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= '0;
      dataQ  <= '0;
      rdQ    <= '0;
      ackQ   <= 1'b0;
      claimQ <= 1'b0;
    end else begin
      ackQ   <= st.ack;
      claimQ <= st.claim;
      if (st.ack) begin
        case (st.rdSel)
          RD_CMD:  rdQ <= {busy, cmdQ};
          RD_DATA: rdQ <= dataQ;
          RD_INT:  rdQ <= intRdata;
          default: rdQ <= '1;
        endcase
      end
      if (st.ldCmd) cmdQ <= busWdata[DATA_W-2:0];
      if (st.ldData)       dataQ <= busWdata;
      else if (st.capInt)  dataQ <= intRdata;
      else if (st.capOnes) dataQ <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intReq   <= 1'b0;
      intWe    <= 1'b0;
      intDev   <= '0;
      intReg   <= '0;
      intWdata <= '0;
    end else if (st.launchInd) begin
      intReq   <= 1'b1;
      intWe    <= (busWdata[OP_LO+1:OP_LO] == OP_WR);
      intDev   <= busWdata[DEV_LO+ADDR_W-1:DEV_LO];
      intReg   <= busWdata[ADDR_W-1:0];
      intWdata <= dataQ;
    end else if (st.launchDir) begin
      intReq   <= 1'b1;
      intWe    <= busWe;
      intDev   <= busPhy;
      intReg   <= busReg;
      intWdata <= busWdata;
    end else if (st.dropReq) begin
      intReq   <= 1'b0;
    end
  end

  // R9: request and its fields hold until acknowledged
  a_r9_req_hold : assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> (intReq && $stable(intWe) && $stable(intDev) &&
                             $stable(intReg) && $stable(intWdata)));

  // R7: the data word does not move while an indirect access is in flight
  a_r7_data_frozen : assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(dataQ));

  // R8: only mapped devices ever see a request
  a_r8_mapped_only : assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> DEV_MASK[intDev]);

  // R2: an unclaimed response floats to all ones
  a_r2_float_ones : assert property (@(posedge clk) disable iff (!rstN)
    (busAck && !busClaim) |-> (busRdData == '1));

endmodule

// File: rtl/mgmt_indirect_slave.sv
module mgmt_indirect_slave
  import mis_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [2**ADDR_W-1:0] DEV_MASK = 'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] chipAddr,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busPhy,
  input  logic [ADDR_W-1:0] busReg,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busAck,
  output logic              busClaim,
  output logic [DATA_W-1:0] busRdData,
  output logic              intReq,
  output logic              intWe,
  output logic [ADDR_W-1:0] intDev,
  output logic [ADDR_W-1:0] intReg,
  output logic [DATA_W-1:0] intWdata,
  input  logic              intAck,
  input  logic [DATA_W-1:0] intRdata
);

  localparam int OP_LO     = 2 * ADDR_W;
  localparam int SHORT_BIT = OP_LO + 2;
  localparam int BUSY_BIT  = DATA_W - 1;

  strobe_t stb;
  logic    busyFlag;
  logic    cmdIsRead;

  mis_ctrl #(
    .ADDR_W  (ADDR_W),
    .DEV_MASK(DEV_MASK)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chipAddr   (chipAddr),
    .busReq     (busReq),
    .busWe      (busWe),
    .busPhy     (busPhy),
    .busReg     (busReg),
    .cmdBusyBit (busWdata[BUSY_BIT]),
    .cmdShortBit(busWdata[SHORT_BIT]),
    .cmdOp      (busWdata[OP_LO+1:OP_LO]),
    .cmdDev     (busWdata[2*ADDR_W-1:ADDR_W]),
    .cmdIsRead  (cmdIsRead),
    .intReq     (intReq),
    .intAck     (intAck),
    .busy       (busyFlag),
    .st         (stb)
  );

  mis_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DEV_MASK(DEV_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (stb),
    .busy     (busyFlag),
    .busWe    (busWe),
    .busPhy   (busPhy),
    .busReg   (busReg),
    .busWdata (busWdata),
    .intAck   (intAck),
    .intRdata (intRdata),
    .busAck   (busAck),
    .busClaim (busClaim),
    .busRdData(busRdData),
    .intReq   (intReq),
    .intWe    (intWe),
    .intDev   (intDev),
    .intReg   (intReg),
    .intWdata (intWdata),
    .cmdIsRead(cmdIsRead)
  );

endmodule

// File: tb/mgmt_indirect_slave_bench.sv
module mgmt_indirect_slave_bench;

  typedef struct {
    logic [15:0] data;
    logic        claim;
    logic        chkData;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  chipAddr = 5'd5;
  logic        busReq = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busPhy = '0;
  logic [4:0]  busReg = '0;
  logic [15:0] busWdata = '0;
  logic        busAck, busClaim;
  logic [15:0] busRdData;
  logic        intReq, intWe;
  logic [4:0]  intDev, intReg;
  logic [15:0] intWdata;
  logic        intAck = 1'b0;
  logic [15:0] intRdata = '0;

  int checks = 0;
  int errors = 0;
  int lat = 8;
  int waitCnt = 0;
  int accCount = 0;
  logic [15:0] mem [0:31][0:31];
  logic        capWe;
  logic [4:0]  capDev, capReg;
  logic [15:0] capWd;
  exp_t        sbQ[$];

  always #2 clk = ~clk;

  mgmt_indirect_slave u_mgmt_indirect_slave (
    .clk(clk), .rstN(rstN), .chipAddr(chipAddr),
    .busReq(busReq), .busWe(busWe), .busPhy(busPhy), .busReg(busReg),
    .busWdata(busWdata), .busAck(busAck), .busClaim(busClaim),
    .busRdData(busRdData), .intReq(intReq), .intWe(intWe), .intDev(intDev),
    .intReg(intReg), .intWdata(intWdata), .intAck(intAck), .intRdata(intRdata)
  );

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // internal register-set responder
  always @(negedge clk) begin
    if (!intReq) begin
      intAck  = 1'b0;
      waitCnt = 0;
    end else if (!intAck) begin
      if (waitCnt == 0) begin
        capWe = intWe; capDev = intDev; capReg = intReg; capWd = intWdata;
      end
      if (waitCnt >= lat) begin
        // R9: fields unchanged across the wait
        check(capWe == intWe && capDev == intDev && capReg == intReg && capWd == intWdata,
              "R9 request fields held", {intDev, intReg, 6'd0}, {capDev, capReg, 6'd0});
        accCount++;
        if (intWe) mem[intDev][intReg] = intWdata;
        intRdata = mem[intDev][intReg];
        intAck   = 1'b1;
      end else begin
        waitCnt++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (busAck) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "unexpected busAck", busRdData, 16'h0);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check(busClaim == e.claim, {e.tag, " claim"}, 16'(busClaim), 16'(e.claim));
        if (e.chkData) check(busRdData == e.data, {e.tag, " data"}, busRdData, e.data);
      end
    end
  end

  task automatic busOp(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic chk, input logic [15:0] expd,
                       input logic expClaim, input string tag, output logic [15:0] rd);
    exp_t e;
    e.data = expd; e.claim = expClaim; e.chkData = chk; e.tag = tag;
    sbQ.push_back(e);
    @(negedge clk);
    busReq = 1'b1; busWe = we; busPhy = phy; busReg = rg; busWdata = wd;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
    while (!busAck) @(negedge clk);
    rd = busRdData;
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                    input logic expClaim, input string tag);
    logic [15:0] junk;
    busOp(1'b1, phy, rg, wd, 1'b0, 16'h0, expClaim, tag, junk);
  endtask

  task automatic rdChk(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] expd,
                       input logic expClaim, input string tag);
    logic [15:0] junk;
    busOp(1'b0, phy, rg, 16'h0, 1'b1, expd, expClaim, tag, junk);
  endtask

  task automatic pollIdle(input string tag);
    logic [15:0] v;
    logic done;
    done = 1'b0;
    for (int i = 0; i < 100 && !done; i++) begin
      busOp(1'b0, chipAddr, 5'd0, 16'h0, 1'b0, 16'h0, 1'b1, tag, v);
      if (!v[15]) done = 1'b1;
    end
    check(done, {tag, " busy cleared"}, 16'(done), 16'h1);
  endtask

  task automatic doReset(input logic [4:0] strap);
    @(negedge clk);
    rstN = 1'b0;
    chipAddr = strap;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int base;
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++)
        mem[d][r] = 16'(d * 256 + r);
    mem[4][2] = 16'h1234;

    repeat (3) @(negedge clk);
    check(busAck == 1'b0, "R1 busAck low in reset", 16'(busAck), 16'h0);
    check(intReq == 1'b0, "R1 intReq low in reset", 16'(intReq), 16'h0);
    doReset(5'd5);
    rdChk(5, 0, 16'h0000, 1'b1, "R1 command word reset");
    rdChk(5, 1, 16'h0000, 1'b1, "R1 data word reset");

    // R5 indirect write: dev 3 reg 7
    lat  = 8;
    base = accCount;
    wr(5, 1, 16'hA5A5, 1'b1, "R5 load data");
    wr(5, 0, 16'h9467, 1'b1, "R5 write command");
    rdChk(5, 0, 16'h9467, 1'b1, "R5 busy reads 1");
    pollIdle("R5");
    check(mem[3][7] == 16'hA5A5, "R5 internal write", mem[3][7], 16'hA5A5);
    check(accCount == base + 1, "R5 one access", 16'(accCount - base), 16'h1);

    // R6 indirect read: dev 4 reg 2
    wr(5, 0, 16'h9882, 1'b1, "R6 read command");
    pollIdle("R6");
    rdChk(5, 1, 16'h1234, 1'b1, "R6 read data");
    // R6 with zero latency: dev 7 reg 3
    lat = 0;
    wr(5, 0, 16'h98E3, 1'b1, "R6 fast read command");
    pollIdle("R6 fast");
    rdChk(5, 1, 16'h0703, 1'b1, "R6 fast read data");

    // R7 writes while busy are ignored (dev 6 reg 1 read)
    lat  = 10;
    base = accCount;
    wr(5, 0, 16'h98C1, 1'b1, "R7 read command");
    wr(5, 1, 16'hDEAD, 1'b1, "R7 data write while busy");
    wr(5, 0, 16'h9467, 1'b1, "R7 command while busy");
    pollIdle("R7");
    rdChk(5, 1, 16'h0601, 1'b1, "R7 data kept read result");
    rdChk(5, 0, 16'h18C1, 1'b1, "R7 command unchanged");
    check(accCount == base + 1, "R7 single access", 16'(accCount - base), 16'h1);
    check(mem[3][7] == 16'hA5A5, "R7 no stray write", mem[3][7], 16'hA5A5);

    // R4 invalid commands start nothing; R3 readback layout
    lat  = 2;
    base = accCount;
    wr(5, 0, 16'h8467, 1'b1, "R4 no format bit");
    rdChk(5, 0, 16'h0467, 1'b1, "R4 no format bit not busy");
    wr(5, 0, 16'h9C67, 1'b1, "R4 opcode 11");
    rdChk(5, 0, 16'h1C67, 1'b1, "R4 opcode 11 not busy");
    wr(5, 0, 16'h1467, 1'b1, "R3 busy bit clear");
    rdChk(5, 0, 16'h1467, 1'b1, "R3 stored bits readback");
    repeat (20) @(negedge clk);
    check(accCount == base, "R4 no internal access", 16'(accCount - base), 16'h0);

    // R8 unmapped device 20
    base = accCount;
    wr(5, 0, 16'h9A80, 1'b1, "R8 unmapped read command");
    pollIdle("R8");
    rdChk(5, 1, 16'hFFFF, 1'b1, "R8 unmapped read ones");
    wr(5, 1, 16'h7777, 1'b1, "R8 load data");
    wr(5, 0, 16'h9680, 1'b1, "R8 unmapped write command");
    pollIdle("R8 write");
    check(accCount == base, "R8 no internal access", 16'(accCount - base), 16'h0);

    // R2 foreign bus address
    rdChk(6, 0, 16'hFFFF, 1'b0, "R2 foreign read");
    wr(6, 1, 16'h1111, 1'b0, "R2 foreign write");
    rdChk(5, 1, 16'h7777, 1'b1, "R2 foreign write no effect");

    // R11 other offsets
    rdChk(5, 3, 16'hFFFF, 1'b1, "R11 spare offset reads ones");
    wr(5, 3, 16'h2222, 1'b1, "R11 spare offset write");
    rdChk(5, 1, 16'h7777, 1'b1, "R11 spare write no effect");

    // R10 direct mode
    doReset(5'd0);
    lat  = 3;
    base = accCount;
    wr(2, 9, 16'hBEEF, 1'b1, "R10 direct write");
    check(mem[2][9] == 16'hBEEF, "R10 direct write landed", mem[2][9], 16'hBEEF);
    rdChk(4, 2, 16'h1234, 1'b1, "R10 direct read");
    rdChk(5, 1, 16'h0501, 1'b1, "R10 no indirection at offset 1");
    rdChk(20, 5, 16'hFFFF, 1'b1, "R10 unmapped direct read");
    check(accCount == base + 3, "R10 direct accesses", 16'(accCount - base), 16'h3);

    repeat (5) @(negedge clk);
    check(sbQ.size() == 0, "scoreboard drained", 16'(sbQ.size()), 16'h0);
    summary();
    $finish;
  end

endmodule